// File: doc/BRIEF.md
# Sign-aware seven-segment display decoder

This block sits behind a converter that time-shares one 4-bit BCD bus between three display positions. A separate active-low strobe marks which position the bus currently holds. The decoder keeps the last value seen for each position in its own latch. It then drives three static seven-segment digits with a decimal point, so no multiplexing reaches the display.

A plain BCD decoder would blank any code above 9. This decoder gives two of those codes a meaning instead, and the meaning depends on the position:

- **Code 10 (1010):** on the most significant position it draws a minus sign. On the lower positions it blanks the digit. A negative overrange frame, which carries 1010 on all three positions, therefore reads as a lone minus sign.
- **Code 11 (1011):** on the most significant position it marks positive overrange. That position then lights segment b alone, and the rest of the display is forced dark.

A one-bit configuration input places the decimal point on either the most significant or the middle position.

Top module: `sevseg_sign_decoder`

## Requirements
- R1: A position's latch takes `bcd_in` on a rising clock edge where that position's strobe is low (`strobe_n[2]` most significant, `strobe_n[1]` middle, `strobe_n[0]` least). A latch whose strobe is high keeps its value whatever the bus carries.
- R2: A latched code 0..9 lights the standard pattern in bits [6:0] = {g,f,e,d,c,b,a}, active high. The patterns are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R3: Code 10 latched on the most significant position lights segment g only, giving 8'h40 on that output.
- R4: These cases blank the digit (all eight bits zero): codes 12..15 on any position, and codes 10 or 11 on the middle or least significant position. A frame of 10,10,10 therefore shows 40, 00, 00.
- R5: Code 11 latched on the most significant position drives that output to 8'h02 (segment b only). It also forces both lower outputs to zero, decimal point included, whatever those positions hold.
- R6: The decimal point is bit 7. With `dp_sel`=0 it may light on the most significant digit, and with `dp_sel`=1 on the middle digit. It lights only while that digit holds a code 0..9 and no positive overrange is present. It never lights on the least significant digit.
- R7: Reset (`rst_n` low, asynchronous) sets every latch to the blank code 15 and every output to zero.
- R8: Outputs are registered. A change of a latch or of `dp_sel` reaches the outputs on the next clock edge, so a strobed code appears two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_in | input | 4 | Shared BCD bus |
| strobe_n | input | 3 | Active-low position strobes, bit 2 most significant |
| dp_sel | input | 1 | Decimal point position: 0 most significant, 1 middle |
| seg_msd | output | 8 | Most significant digit {dp,g,f,e,d,c,b,a} |
| seg_nsd | output | 8 | Middle digit {dp,g,f,e,d,c,b,a} |
| seg_lsd | output | 8 | Least significant digit {dp,g,f,e,d,c,b,a} |

## Verification
Some properties are checked by assertions on every cycle:

- each latch loads when strobed and holds otherwise;
- a minus code on the top position yields segment g alone;
- a positive overrange forces the whole frame to b-only and blanks;
- a non-numeric code on the low position is blank;
- at most one decimal point is lit, and never on the low position.

Other behaviour only the bench's scenarios can show. That covers the exact pattern of every numeral, the dp_sel placement and its suppression on signs, reset values, and hold while the bus changes unstrobed. The bench also covers the two-edge latency, which it checks by comparing against a cycle model on every clock.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;
  localparam int CODE_W   = 4;
  localparam int SEG_W    = 8;
  localparam int N_DIGITS = 3;
  localparam int MSD_IDX  = N_DIGITS - 1;
  localparam int NSD_IDX  = N_DIGITS - 2;

  localparam logic [CODE_W-1:0] CODE_MINUS  = 4'd10;
  localparam logic [CODE_W-1:0] CODE_POSOVR = 4'd11;
  localparam logic [CODE_W-1:0] CODE_BLANK  = 4'd15;

  localparam logic [6:0] PAT_MINUS = 7'b100_0000;
  localparam logic [6:0] PAT_SEG_B = 7'b000_0010;

  function automatic logic is_numeral(input logic [CODE_W-1:0] code);
    return code <= 4'd9;
  endfunction

  // segment pattern {g,f,e,d,c,b,a} for a decimal numeral, dark otherwise
  function automatic logic [6:0] numeral_pattern(input logic [CODE_W-1:0] code);
    logic [6:0] p;
    case (code)
      4'd0: p = 7'h3F;
      4'd1: p = 7'h06;
      4'd2: p = 7'h5B;
      4'd3: p = 7'h4F;
      4'd4: p = 7'h66;
      4'd5: p = 7'h6D;
      4'd6: p = 7'h7D;
      4'd7: p = 7'h07;
      4'd8: p = 7'h7F;
      4'd9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/digit_latch.sv
module digit_latch
  import sevseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= CODE_BLANK;
    else if (!load_n) q <= d;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(d)); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(q)); // R1
endmodule

// File: rtl/digit_encoder.sv
module digit_encoder
  import sevseg_pkg::*;
#(
  parameter bit IS_MSD = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  input  logic              pos_ovr,
  input  logic              dp_here,
  output logic [SEG_W-1:0]  seg
);
  logic [6:0] body;
  logic       dot;

  generate
    if (IS_MSD) begin : g_msd
      always_comb begin
        if (code == CODE_MINUS)       body = PAT_MINUS;
        else if (code == CODE_POSOVR) body = PAT_SEG_B;
        else                          body = numeral_pattern(code);
        dot = dp_here && is_numeral(code);
      end
    end else begin : g_low
      always_comb begin
        body = pos_ovr ? 7'h00 : numeral_pattern(code);
        dot  = dp_here && !pos_ovr && is_numeral(code);
      end
    end
  endgenerate

  assign seg = {dot, body};
endmodule

// File: rtl/sevseg_sign_decoder.sv
module sevseg_sign_decoder
  import sevseg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   bcd_in,
  input  logic [N_DIGITS-1:0] strobe_n,
  input  logic                dp_sel,
  output logic [SEG_W-1:0]    seg_msd,
  output logic [SEG_W-1:0]    seg_nsd,
  output logic [SEG_W-1:0]    seg_lsd
);
  logic [CODE_W-1:0] lat   [N_DIGITS];
  logic [SEG_W-1:0]  seg_d [N_DIGITS];
  logic [SEG_W-1:0]  seg_q [N_DIGITS];

  // named events for the assertions
  logic pos_ovr;
  logic msd_minus;
  logic lsd_nonnum;
  assign pos_ovr    = (lat[MSD_IDX] == CODE_POSOVR);
  assign msd_minus  = (lat[MSD_IDX] == CODE_MINUS);
  assign lsd_nonnum = !is_numeral(lat[0]);

  genvar k;
  generate
    for (k = 0; k < N_DIGITS; k++) begin : g_pos
      logic dp_here;
      if (k == MSD_IDX) begin : g_dp_msd
        assign dp_here = !dp_sel;
      end else if (k == NSD_IDX) begin : g_dp_nsd
        assign dp_here = dp_sel;
      end else begin : g_dp_none
        assign dp_here = 1'b0;
      end

      digit_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (strobe_n[k]),
        .d      (bcd_in),
        .q      (lat[k])
      );

      digit_encoder #(.IS_MSD(k == MSD_IDX)) u_enc (
        .code    (lat[k]),
        .pos_ovr (pos_ovr),
        .dp_here (dp_here),
        .seg     (seg_d[k])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_q[k] <= '0;
        else        seg_q[k] <= seg_d[k];
      end
    end
  endgenerate

  assign seg_msd = seg_q[MSD_IDX];
  assign seg_nsd = seg_q[NSD_IDX];
  assign seg_lsd = seg_q[0];

  AST_POSOVR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    pos_ovr |=> (seg_msd == 8'h02 && seg_nsd == 8'h00 && seg_lsd == 8'h00)); // R5
  AST_MINUS_G_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    msd_minus |=> seg_msd == 8'h40); // R3
  AST_LSD_NONNUM_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    lsd_nonnum |=> seg_lsd == 8'h00); // R4
  AST_DP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_msd[7], seg_nsd[7], seg_lsd[7]})); // R6
  AST_LSD_NO_DP: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_lsd[7]); // R6
endmodule

// File: tb/sevseg_sign_decoder_bench.sv
`timescale 1ns/1ps
module sevseg_sign_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bcd_in = 4'd0;
  logic [2:0] strobe_n = 3'b111;
  logic       dp_sel = 1'b0;
  logic [7:0] seg_msd, seg_nsd, seg_lsd;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sevseg_sign_decoder u_sevseg_sign_decoder (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .strobe_n(strobe_n),
    .dp_sel(dp_sel), .seg_msd(seg_msd), .seg_nsd(seg_nsd), .seg_lsd(seg_lsd)
  );

  // behavioural segment sets per numeral
  function automatic logic [6:0] ref_numeral(input int v);
    logic [6:0] s;
    s[0] = !(v inside {1, 4});
    s[1] = !(v inside {5, 6});
    s[2] = (v != 2);
    s[3] = !(v inside {1, 4, 7});
    s[4] = (v inside {0, 2, 6, 8});
    s[5] = !(v inside {1, 2, 3, 7});
    s[6] = !(v inside {0, 1, 7});
    return s;
  endfunction

  function automatic logic [7:0] ref_digit(input int pos, input int code,
                                           input int top, input bit dsel);
    bit ovr = (top == 11);
    bit num = (code <= 9);
    bit dp_pos = (pos == 2 && !dsel) || (pos == 1 && dsel);
    logic [7:0] r = 8'h00;
    if (pos == 2) begin
      if (num)             r = {1'b0, ref_numeral(code)};
      else if (code == 10) r = 8'h40;
      else if (code == 11) r = 8'h02;
    end else if (!ovr && num) begin
      r = {1'b0, ref_numeral(code)};
    end
    if (dp_pos && num && !ovr) r[7] = 1'b1;
    return r;
  endfunction

  // cycle model
  int         m_lat [3] = '{15, 15, 15};
  logic [7:0] m_out [3] = '{8'h00, 8'h00, 8'h00};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_lat[i] <= 15;
        m_out[i] <= 8'h00;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        m_out[i] <= ref_digit(i, m_lat[i], m_lat[2], dp_sel);
        if (!strobe_n[i]) m_lat[i] <= int'(bcd_in);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // model comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R8 model msd", seg_msd, m_out[2]);
      check("R8 model nsd", seg_nsd, m_out[1]);
      check("R8 model lsd", seg_lsd, m_out[0]);
    end
  end

  task automatic load(input int pos, input int code);
    @(negedge clk);
    strobe_n = ~(3'b001 << pos);
    bcd_in = code[3:0];
    @(negedge clk);
    strobe_n = 3'b111;
  endtask

  task automatic frame(input int hi, input int mid, input int lo);
    load(2, hi);
    load(1, mid);
    load(0, lo);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset msd", seg_msd, 8'h00);
    check("R7 reset lsd", seg_lsd, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 after reset nsd", seg_nsd, 8'h00);

    dp_sel = 1'b0;
    frame(1, 2, 3);
    check("R2 R6 msd 1 with dp", seg_msd, 8'h86);
    check("R2 nsd 2", seg_nsd, 8'h5B);
    check("R2 lsd 3", seg_lsd, 8'h4F);

    // R8: a strobed code is not visible after one edge, visible after two
    @(negedge clk);
    strobe_n = 3'b110; bcd_in = 4'd8;
    @(negedge clk);
    strobe_n = 3'b111;
    check("R8 one edge old lsd", seg_lsd, 8'h4F);
    @(negedge clk);
    check("R8 two edges lsd 8", seg_lsd, 8'h7F);

    dp_sel = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 dp moved off msd", seg_msd, 8'h06);
    check("R6 dp on nsd", seg_nsd, 8'hDB);

    for (int v = 0; v < 10; v++) begin
      frame(v, 9 - v, v);
      check("R2 numeral msd", seg_msd, {1'b0, ref_numeral(v)});
      check("R2 numeral lsd", seg_lsd, {1'b0, ref_numeral(v)});
    end

    // R1: bus changes without strobe
    frame(4, 5, 6);
    bcd_in = 4'd9;
    repeat (4) @(negedge clk);
    check("R1 hold msd", seg_msd, 8'h66);
    check("R1 hold nsd", seg_nsd, 8'hED);
    check("R1 hold lsd", seg_lsd, 8'h7D);

    dp_sel = 1'b0;
    frame(10, 4, 5);
    check("R3 minus msd", seg_msd, 8'h40);
    check("R6 no dp on minus", seg_msd[7], 1'b0);
    check("R3 nsd 4", seg_nsd, 8'h66);

    frame(10, 10, 10);
    check("R4 neg ovr msd", seg_msd, 8'h40);
    check("R4 neg ovr nsd", seg_nsd, 8'h00);
    check("R4 neg ovr lsd", seg_lsd, 8'h00);

    frame(12, 15, 13);
    check("R4 code 12 msd", seg_msd, 8'h00);
    check("R4 code 15 nsd", seg_nsd, 8'h00);
    check("R4 code 13 lsd", seg_lsd, 8'h00);
    frame(2, 11, 14);
    check("R4 code 11 low nsd", seg_nsd, 8'h00);
    check("R4 code 14 lsd", seg_lsd, 8'h00);

    dp_sel = 1'b1;
    frame(11, 7, 8);
    check("R5 pos ovr msd", seg_msd, 8'h02);
    check("R5 pos ovr nsd dark", seg_nsd, 8'h00);
    check("R5 pos ovr lsd dark", seg_lsd, 8'h00);
    load(1, 3);
    repeat (2) @(negedge clk);
    check("R5 nsd stays dark", seg_nsd, 8'h00);
    load(2, 5);
    repeat (2) @(negedge clk);
    check("R5 release nsd 3 dp", seg_nsd, 8'hCF);
    check("R5 release lsd 8", seg_lsd, 8'h7F);

    rst_n = 1'b0;
    @(negedge clk);
    check("R7 async reset msd", seg_msd, 8'h00);
    check("R7 async reset nsd", seg_nsd, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 latches blank lsd", seg_lsd, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule